// File: doc/BRIEF.md
# Antibacklash Phase-Frequency Detector

This block compares two slow pulse trains inside a fast system clock domain. One train comes from the divided reference and the other from the divided feedback of a phase-locked loop. It drives two charge-pump control outputs. The pump-raise output goes high on a rising edge of the reference input. The pump-lower output goes high on a rising edge of the feedback input. Once both are high, a short programmable hold time passes and then both drop in the same cycle. The hold time forces every comparison to produce a pulse of known minimum width on both outputs, even when the two inputs are perfectly aligned. This removes the dead zone near zero phase error.

Both inputs are treated as asynchronous. Each passes through a synchronizer and a one-cycle-delayed copy to find its rising edges. A 2-bit hold code chooses the overlap length. A power-down input forces both outputs low and discards all pending state.

Top module: `phase_freq_det`

## Requirements
- R1: While `rst_n` is low, `up` and `dn` are 0. After `rst_n` rises, no pulse appears until a new rising edge is seen on an input.
- R2: `ref_in` may first be sampled high at clock edge k after being low at edge k-1. `up` is then high after edge k+2 (the third edge), and not after edge k+1. This holds with the default two-stage synchronizer.
- R3: A rising edge on `fb_in` raises `dn` with the same latency as R2.
- R4: From the first cycle in which `up` and `dn` are both high, they stay high together for D cycles and then fall in the same cycle. D is chosen by `abw_code`: code 0 gives 3, code 1 gives 1, code 2 gives 6 and code 3 gives 3.
- R5: When both inputs rise in the same cycle, both outputs rise in the same cycle and both pulse for exactly D cycles.
- R6: A further rising edge on an input whose output is already high has no effect. Once the pair clears, that output stays low until a fresh edge arrives.
- R7: When only one output is high, it stays high for as long as the other input shows no rising edge.
- R8: An input edge may reach the detector in the same cycle the pair is being cleared. Its output is then high again in the next cycle, so the edge is not lost.
- R9: While `pwr_dn` is 1, `up` and `dn` are 0 in that same cycle. Edges seen during power-down are discarded. After `pwr_dn` returns to 0, both outputs stay low until new edges arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_in | input | 1 | Divided reference pulse train (asynchronous) |
| fb_in | input | 1 | Divided feedback pulse train (asynchronous) |
| abw_code | input | 2 | Antibacklash hold-time select |
| pwr_dn | input | 1 | Power-down: forces outputs low and drops state |
| up | output | 1 | Charge-pump raise command |
| dn | output | 1 | Charge-pump lower command |

## Verification
The inputs are driven with aligned edges, with the reference leading the feedback and with the feedback leading the reference. Each pattern is swept over offsets of zero to nine cycles and run under all four hold codes. The aligned case separates a working antibacklash overlap from a dead zone. The one-sided cases separate correct overlap counting from early or late clearing. Two directed cases cover extra edges during a held output and an edge that lands exactly on the clear cycle. Together they show whether the flag logic drops an edge or remembers an edge it should forget. Power-down is applied both while flags are set and while edges arrive, to show that state is discarded and not just masked.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int unsigned ABW_W = 2;
  localparam int unsigned CNT_W = 3;

  typedef logic [ABW_W-1:0] abw_code_t;
  typedef logic [CNT_W-1:0] hold_cnt_t;

  // Overlap length in system-clock cycles for each hold code.
  function automatic hold_cnt_t abw_cycles(input abw_code_t code);
    hold_cnt_t len;
    unique case (code)
      2'd1:    len = hold_cnt_t'(1);
      2'd2:    len = hold_cnt_t'(6);
      default: len = hold_cnt_t'(3);
    endcase
    return len;
  endfunction

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pfd_flag.sv
module pfd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic pd,
  output logic q
);

  logic q_q;
  logic q_d;

  always_comb begin
    if (pd)       q_d = 1'b0;
    else if (clr) q_d = set;          // an edge on the clear cycle re-arms
    else          q_d = q_q | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      both,
  input  abw_code_t code,
  input  logic      pd,
  output logic      clr
);

  hold_cnt_t cnt_q;
  hold_cnt_t cnt_d;
  hold_cnt_t lim;
  logic      cnt_en;
  logic      expire;

  always_comb begin
    lim    = abw_cycles(code);
    cnt_en = both & ~pd;
    // >= keeps the overlap bounded if the code shrinks mid-count
    expire = cnt_en & (cnt_q >= (lim - hold_cnt_t'(1)));
    if (!cnt_en || expire) cnt_d = '0;
    else                   cnt_d = cnt_q + hold_cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign clr = expire;

endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic [1:0] abw_code,
  input  logic       pwr_dn,
  output logic       up,
  output logic       dn
);

  localparam int unsigned NCH = 2;

  logic           srst_n;
  logic [NCH-1:0] in_vec;
  logic [NCH-1:0] rise_vec;
  logic [NCH-1:0] flag_vec;
  logic           both_set;
  logic           pair_clr;

  pfd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign in_vec = {fb_in, ref_in};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (srst_n),
      .din   (in_vec[ch]),
      .rise  (rise_vec[ch])
    );
    pfd_flag u_flag (
      .clk   (clk),
      .rst_n (srst_n),
      .set   (rise_vec[ch]),
      .clr   (pair_clr),
      .pd    (pwr_dn),
      .q     (flag_vec[ch])
    );
  end

  assign both_set = &flag_vec;

  pfd_abl_timer u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .both  (both_set),
    .code  (abw_code_t'(abw_code)),
    .pd    (pwr_dn),
    .clr   (pair_clr)
  );

  assign up = flag_vec[0] & ~pwr_dn;
  assign dn = flag_vec[1] & ~pwr_dn;

endmodule

// File: rtl/pfd_chk.sv
module pfd_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_dn,
  input logic up,
  input logic dn,
  input logic rise_up,
  input logic rise_dn
);

  localparam int unsigned MAX_OVL = 6;

  logic [3:0] ovl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovl_q <= '0;
    else if (up && dn)  ovl_q <= ovl_q + 4'd1;
    else                ovl_q <= '0;
  end

  // R2
  up_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(rise_up));

  // R3
  dn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(rise_dn));

  // R4
  pair_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(up) && !pwr_dn) |-> $past(dn));

  // R4
  ovl_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |-> (ovl_q < MAX_OVL));

  // R9
  pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!up && !dn));

  // R7
  lone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && !pwr_dn) |=> (up || pwr_dn));

endmodule

bind phase_freq_det pfd_chk u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .pwr_dn  (pwr_dn),
  .up      (up),
  .dn      (dn),
  .rise_up (rise_vec[0]),
  .rise_dn (rise_vec[1])
);

// File: tb/sim_phase_freq_det.sv
module sim_phase_freq_det;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_in;
  logic       fb_in;
  logic [1:0] abw_code;
  logic       pwr_dn;
  logic       up;
  logic       dn;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  phase_freq_det u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .fb_in    (fb_in),
    .abw_code (abw_code),
    .pwr_dn   (pwr_dn),
    .up       (up),
    .dn       (dn)
  );

  // ---------------- behavioural reference model ----------------
  bit rq[$];
  bit fq[$];
  bit mu, md;
  int mc;

  function automatic int hold_len(input logic [1:0] c);
    case (c)
      2'd1:    return 1;
      2'd2:    return 6;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rq = '{0, 0, 0};
      fq = '{0, 0, 0};
      mu = 0; md = 0; mc = 0;
    end else begin
      bit eu, ed, both, clr;
      eu = rq[1] && !rq[2];
      ed = fq[1] && !fq[2];
      rq.push_front(ref_in); void'(rq.pop_back());
      fq.push_front(fb_in);  void'(fq.pop_back());
      if (pwr_dn) begin
        mu = 0; md = 0; mc = 0;
      end else begin
        both = mu && md;
        clr  = both && (mc >= hold_len(abw_code) - 1);
        mc   = (both && !clr) ? mc + 1 : 0;
        mu   = clr ? eu : (mu || eu);
        md   = clr ? ed : (md || ed);
      end
    end
  end

  // Cycle-by-cycle compare, a quarter period after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (!done) begin
        bit eu_x, ed_x;
        eu_x = mu && !pwr_dn;
        ed_x = md && !pwr_dn;
        n_vec++;
        if (up !== eu_x || dn !== ed_x) begin
          n_bad++;
          $display("FAIL %s model: up/dn=%b%b expected %b%b at %0t",
                   cur_req, up, dn, eu_x, ed_x, $time);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic after_edge();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ref_in = 0; fb_in = 0; abw_code = 2'd0; pwr_dn = 0;
    cyc(4);
    // R1: reset holds outputs low
    check(up == 0 && dn == 0, "R1", "reset outputs", {up, dn}, 2'b00);
    rst_n = 1'b1;
    cyc(10);
    check(up == 0 && dn == 0, "R1", "idle after reset", {up, dn}, 2'b00);

    // R2: latency of the reference edge
    cur_req = "R2";
    @(negedge clk); ref_in = 1;
    @(posedge clk);               // edge k samples high
    after_edge();                 // edge k+1
    check(up == 0, "R2", "up before third edge", {1'b0, up}, 2'b00);
    after_edge();                 // edge k+2
    check(up == 1, "R2", "up at third edge", {1'b0, up}, 2'b01);

    // R7: lone output holds
    cur_req = "R7";
    cyc(20);
    check(up == 1 && dn == 0, "R7", "lone up held", {up, dn}, 2'b10);

    // R3 + R4: feedback edge, code 0 overlap of 3
    cur_req = "R4";
    @(negedge clk); fb_in = 1;
    @(posedge clk);
    after_edge();
    check(dn == 0, "R3", "dn before third edge", {1'b0, dn}, 2'b00);
    after_edge();                 // overlap cycle 1
    check(dn == 1 && up == 1, "R3", "dn at third edge", {up, dn}, 2'b11);
    after_edge(); after_edge();   // overlap cycles 2,3
    check(up == 1 && dn == 1, "R4", "overlap last cycle", {up, dn}, 2'b11);
    after_edge();
    check(up == 0 && dn == 0, "R4", "cleared together", {up, dn}, 2'b00);
    cyc(2); ref_in = 0; fb_in = 0; cyc(8);

    // R5: aligned edges under each code
    cur_req = "R5";
    for (int c = 0; c < 4; c++) begin
      int hi;
      @(negedge clk); abw_code = 2'(c); cyc(2);
      ref_in = 1; fb_in = 1;
      hi = 0;
      repeat (14) begin
        after_edge();
        if (up && dn) hi++;
      end
      check(hi == hold_len(2'(c)), "R5", "aligned overlap length",
            2'(hi), 2'(hold_len(2'(c))));
      @(negedge clk); ref_in = 0; fb_in = 0; cyc(6);
    end

    // R6: extra reference edges while up is held are not stored
    cur_req = "R6";
    @(negedge clk); abw_code = 2'd0;
    ref_in = 1; cyc(2); ref_in = 0; cyc(2); ref_in = 1; cyc(2); ref_in = 0;
    cyc(5); fb_in = 1; cyc(12);
    check(up == 0 && dn == 0, "R6", "no stored extra edge", {up, dn}, 2'b00);
    fb_in = 0; cyc(6);

    // R8: reference edge on the clear cycle re-arms up
    cur_req = "R8";
    abw_code = 2'd1;
    ref_in = 1; cyc(3); ref_in = 0; cyc(2);
    fb_in = 1;                    // sampled at edge j
    cyc(1); ref_in = 1;           // sampled at edge j+1 -> clear cycle
    cyc(6);
    check(up == 1 && dn == 0, "R8", "re-armed on clear", {up, dn}, 2'b10);
    fb_in = 1; ref_in = 0; cyc(1); fb_in = 0; cyc(4);
    fb_in = 1; cyc(12); fb_in = 0; cyc(8);
    check(up == 0 && dn == 0, "R8", "pair drained", {up, dn}, 2'b00);

    // R9: power-down masks at once and drops state
    cur_req = "R9";
    abw_code = 2'd0;
    ref_in = 1; cyc(6);
    pwr_dn = 1; #1;
    check(up == 0 && dn == 0, "R9", "masked same cycle", {up, dn}, 2'b00);
    cyc(2); ref_in = 0; fb_in = 1; cyc(6);
    pwr_dn = 0; cyc(10);
    check(up == 0 && dn == 0, "R9", "state dropped", {up, dn}, 2'b00);
    fb_in = 0; cyc(6);

    // R4: offset sweep, both orders, all codes
    cur_req = "R4";
    for (int c = 0; c < 4; c++) begin
      for (int off = 0; off < 10; off++) begin
        for (int lead = 0; lead < 2; lead++) begin
          @(negedge clk); abw_code = 2'(c);
          if (lead == 0) ref_in = 1; else fb_in = 1;
          cyc(off);
          ref_in = 1; fb_in = 1;
          cyc(3);
          ref_in = 0; fb_in = 0;
          cyc(12);
        end
      end
    end

    cyc(4);
    finish_run();
  end

endmodule